// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive Queues

This block is a register-mapped SPI master. Software sets a clock divisor and a control word, then writes frames into an eight-entry transmit queue. As long as the block is switched on and set to act as master, the shifter pulls frames from that queue and sends them one after another without a gap. Each frame sends its bits on `mosi_o`, driven by `sclk_o`, and at the same time collects the same number of bits from `miso_i` (or from its own `mosi_o` when loopback is on). Each finished frame places one received word into an eight-entry receive queue, and software pops that queue by reading the receive data register.

A frame can be 1 to 16 bits long. The clock polarity, the clock phase and the bit order can each be chosen. A level interrupt tells software that everything it queued has left the shifter, so it can read back up to a full queue of results and write the next burst. A soft-reset control bit flushes both queues and stops the shifter while the bit stays set. Chip select is not part of this block; it is driven from outside.

Top module: `spi_fifo_master`

## Requirements
- R1: Out of reset, `sclk_o`, `mosi_o` and `irq_o` are 0. The divisor and control registers read back 0, and a read of the receive register returns 0.
- R2: The divisor sits at offset 0x00, transmit data at 0x04, receive data at 0x08, control at 0x0C and interrupt enable at 0x10 (bit 2). The divisor, control and interrupt-enable registers read back what was written to them.
- R3: While a frame is in progress, every half period of `sclk_o` lasts exactly D system clocks, where D is the 16-bit divisor value. A divisor of 0 gives a half period of 65536 clocks.
- R4: Control bits [3:0] hold the frame length minus one. Transmit bits above the frame length are ignored. Received words are right-justified, with zeros above the frame length.
- R5: When control bit 4 is set, the most significant bit of the frame goes out first. When it is clear, the least significant bit goes out first. Received bits are placed in the same order.
- R6: Control bit 6 sets the idle level of `sclk_o`. When control bit 5 is clear, data is sampled on the leading edge of each clock pulse and changed on the trailing edge. When bit 5 is set, data is changed on the leading edge and sampled on the trailing edge.
- R7: When control bit 10 is set, the receive path takes its bits from `mosi_o` inside the block. Otherwise it samples `miso_i`.
- R8: Frames are sent only while control bit 9 (enable) and bit 8 (master) are both set. If either bit is clear, queued frames stay in the transmit queue and `sclk_o` stays at its idle level.
- R9: Each queue holds 8 words while its enable bit is set (bit 11 for transmit, bit 12 for receive), and 1 word while that bit is clear. A transmit write to a full queue is dropped.
- R10: A read of the receive register pops one word. A read of an empty receive queue returns 0. A frame that finishes while the receive queue is full is discarded, and the words already held are kept.
- R11: Frames that are queued together are sent back-to-back: N frames of W bits produce 2·N·W clock edges, spaced evenly D clocks apart.
- R12: `irq_o` is high exactly when interrupt-enable bit 2 is set, the transmit queue is empty and the shifter is idle. Writing 0 to the enable register lowers it.
- R13: While control bit 7 is set, both queues are emptied, any frame in progress is abandoned without writing a receive word, and `sclk_o` sits at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops the receive queue at offset 0x08) |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transmit-drained interrupt, level |

## Verification
The bench uses the default parameters: 16-bit maximum frame, 8-entry queues and a 16-bit divisor. With these values the bench can overfill both queues, run full-width 16-bit frames, and reach the 65536-clock half period that a zero divisor selects. A scoreboard rebuilds each frame from `sclk_o` and `mosi_o` for every polarity, phase and bit-order setting, and checks it against the words that were queued. Edge timestamps check the divisor timing and confirm there are no gaps between frames.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int WFIELD_W = 4;   // frame length field, length minus one
    localparam int IEN_BIT  = 2;   // interrupt-enable bit position

    localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TX   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RX   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h10;

    // Control word, MSB first: field positions are software-visible.
    typedef struct packed {
        logic                rx_q_en;    // 12
        logic                tx_q_en;    // 11
        logic                loop;       // 10
        logic                enable;     // 9
        logic                master;     // 8
        logic                soft_rst;   // 7
        logic                cpol;       // 6
        logic                cpha;       // 5
        logic                msb_first;  // 4
        logic [WFIELD_W-1:0] len_m1;     // 3:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIV,
        SEL_TX,
        SEL_RX,
        SEL_CTRL,
        SEL_IEN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_DIV:  return SEL_DIV;
            OFS_TX:   return SEL_TX;
            OFS_RX:   return SEL_RX;
            OFS_CTRL: return SEL_CTRL;
            OFS_IEN:  return SEL_IEN;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Position within the word of the n-th bit on the wire.
    function automatic logic [WFIELD_W-1:0] wire_slot(
        input logic                msb,
        input logic [WFIELD_W-1:0] len_m1,
        input logic [WFIELD_W-1:0] n
    );
        return msb ? (len_m1 - n) : n;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             single_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;

    always_comb begin
        empty_o = (count_q == '0);
        full_o  = single_i ? (count_q != '0) : (count_q == CNT_W'(DEPTH));
        push_ok = push_i && !full_o;
        pop_ok  = pop_i && !empty_o;
        rdata_o = mem_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_q == PTR_W'(g)) mem_q[g] <= wdata_i;
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R9/R10: a push into a full queue leaves the occupancy untouched
    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i && !flush_i) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // A divisor of 0 wraps to all ones: 2**DIV_W clocks per half period.
    always_comb begin
        limit  = div_i - DIV_W'(1);
        tick_o = run_i && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                halt_i,
    input  logic                start_i,
    input  logic                tick_i,
    input  logic [DATA_W-1:0]   tx_data_i,
    input  logic [WFIELD_W-1:0] len_m1_i,
    input  logic                msb_i,
    input  logic                cpol_i,
    input  logic                cpha_i,
    input  logic                sdi_i,
    output logic                busy_o,
    output logic                sclk_o,
    output logic                sdo_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   rx_data_o
);
    localparam int EDGE_W = WFIELD_W + 1;

    logic                busy_q, sclk_q, sdo_q;
    logic [EDGE_W-1:0]   edge_q;
    logic [DATA_W-1:0]   tx_q, rx_q, rx_next;
    logic                edge_ev, leading, sample_now, drive_now, last_edge;
    logic [WFIELD_W-1:0] bit_n, in_slot, out_slot, first_slot;

    always_comb begin
        edge_ev    = busy_q && tick_i;
        leading    = !edge_q[0];
        bit_n      = edge_q[EDGE_W-1:1];
        last_edge  = (edge_q == {len_m1_i, 1'b1});
        sample_now = cpha_i ? !leading : leading;
        drive_now  = cpha_i ? leading : (!leading && !last_edge);
        in_slot    = wire_slot(msb_i, len_m1_i, bit_n);
        out_slot   = wire_slot(msb_i, len_m1_i, cpha_i ? bit_n : bit_n + 1'b1);
        first_slot = wire_slot(msb_i, len_m1_i, '0);
        rx_next    = rx_q;
        if (edge_ev && sample_now) rx_next[in_slot] = sdi_i;
        done_o     = edge_ev && last_edge;
        busy_o     = busy_q;
        sclk_o     = sclk_q;
        sdo_o      = sdo_q;
        rx_data_o  = rx_next;
    end

    always_ff @(posedge clk) begin
        if (rst || halt_i) begin
            busy_q <= 1'b0;
            sclk_q <= rst ? 1'b0 : cpol_i;
            sdo_q  <= 1'b0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            sclk_q <= cpol_i;
            edge_q <= '0;
            tx_q   <= tx_data_i;
            rx_q   <= '0;
            if (!cpha_i) sdo_q <= tx_data_i[first_slot];
        end else if (edge_ev) begin
            sclk_q <= !sclk_q;
            edge_q <= edge_q + 1'b1;
            rx_q   <= rx_next;
            if (drive_now) sdo_q <= tx_q[out_slot];
            if (last_edge) busy_q <= 1'b0;
        end else if (!busy_q) begin
            sclk_q <= cpol_i;
        end
    end

    // R3: the serial clock only moves on a divider tick while a frame runs
    a_r3_sclk_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick_i && !halt_i) |=> $stable(sclk_q));

    // R11: a reload at the end of a frame keeps the shifter busy
    a_r11_reload: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i && !halt_i) |=> busy_q);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              irq_o
);
    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic              ien_q, irq_q;

    logic              go, start, busy, done, tick, sdi;
    logic [DATA_W-1:0] tx_head, rx_word, rx_head;
    logic              tx_full, tx_empty, rx_full, rx_empty;

    assign sel = decode_addr(bus_addr_i);

    // Register file
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            ctrl_q <= '0;
            ien_q  <= 1'b0;
        end else if (bus_wr_i) begin
            case (sel)
                SEL_DIV:  div_q  <= bus_wdata_i[DIV_W-1:0];
                SEL_CTRL: ctrl_q <= bus_wdata_i[CTRL_W-1:0];
                SEL_IEN:  ien_q  <= bus_wdata_i[IEN_BIT];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_DIV:  bus_rdata_o = BUS_W'(div_q);
            SEL_RX:   bus_rdata_o = rx_empty ? '0 : BUS_W'(rx_head);
            SEL_CTRL: bus_rdata_o = BUS_W'(ctrl_q);
            SEL_IEN:  bus_rdata_o = BUS_W'(ien_q) << IEN_BIT;
            default:  bus_rdata_o = '0;
        endcase
    end

    // Frame launch: idle shifter, or the last edge of the current frame
    always_comb begin
        go    = ctrl_q.enable && ctrl_q.master && !ctrl_q.soft_rst;
        start = go && !tx_empty && (!busy || done);
        sdi   = ctrl_q.loop ? mosi_o : miso_i;
    end

    spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (ctrl_q.soft_rst),
        .single_i (!ctrl_q.tx_q_en),
        .push_i   (bus_wr_i && sel == SEL_TX),
        .wdata_i  (bus_wdata_i[DATA_W-1:0]),
        .pop_i    (start),
        .rdata_o  (tx_head),
        .full_o   (tx_full),
        .empty_o  (tx_empty)
    );

    spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (ctrl_q.soft_rst),
        .single_i (!ctrl_q.rx_q_en),
        .push_i   (done),
        .wdata_i  (rx_word),
        .pop_i    (bus_rd_i && sel == SEL_RX),
        .rdata_o  (rx_head),
        .full_o   (rx_full),
        .empty_o  (rx_empty)
    );

    spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy && !ctrl_q.soft_rst),
        .div_i  (div_q),
        .tick_o (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .halt_i    (ctrl_q.soft_rst),
        .start_i   (start),
        .tick_i    (tick),
        .tx_data_i (tx_head),
        .len_m1_i  (ctrl_q.len_m1),
        .msb_i     (ctrl_q.msb_first),
        .cpol_i    (ctrl_q.cpol),
        .cpha_i    (ctrl_q.cpha),
        .sdi_i     (sdi),
        .busy_o    (busy),
        .sclk_o    (sclk_o),
        .sdo_o     (mosi_o),
        .done_o    (done),
        .rx_data_o (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ien_q && tx_empty && !busy;
    end
    assign irq_o = irq_q;

    a_r13_soft_reset_idle: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.soft_rst |=> (!busy && sclk_o == $past(ctrl_q.cpol)));

    a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(ien_q));

    a_r8_no_launch_when_off: assert property (@(posedge clk) disable iff (rst)
        (!go && !busy) |=> !busy);

    // R9: a full transmit queue still has its head word present
    a_r9_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_empty);

endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
    import spi_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_fifo_master i_spi_fifo_master (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .miso_i      (miso),
        .irq_o       (irq)
    );

    int     nchk = 0, nfail = 0;
    longint cyc = 0;
    bit     finished = 0;
    always @(posedge clk) cyc++;

    // Bench view of the configured mode
    int tb_wm1 = 7;
    bit tb_msb = 1, tb_cpha = 0, tb_cpol = 0;
    bit mon_on = 0;
    int mon_nb = 0;
    logic [15:0] mon_word = '0;
    logic [15:0] exp_q[$];

    int     edge_cnt = 0;
    longint first_edge = 0, second_edge = 0, last_edge = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_w(input int wm1);
        return (32'h1 << (wm1 + 1)) - 32'h1;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Driver: queue a frame and, if it is expected on the wire, its scoreboard entry
    task automatic send(input logic [31:0] d, input bit expect_it);
        wr(OFS_TX, d);
        if (expect_it) exp_q.push_back(16'(d & mask_w(tb_wm1)));
    endtask

    task automatic cfg(input int wm1, input bit msb, input bit cpha, input bit cpol,
                       input bit master, input bit en, input bit loop,
                       input bit qen, input bit srst);
        logic [31:0] c;
        mon_on = 0;
        tb_wm1 = wm1; tb_msb = msb; tb_cpha = cpha; tb_cpol = cpol;
        c = 32'(wm1) | (32'(msb) << 4) | (32'(cpha) << 5) | (32'(cpol) << 6)
          | (32'(srst) << 7) | (32'(master) << 8) | (32'(en) << 9)
          | (32'(loop) << 10) | (32'(qen) << 11) | (32'(qen) << 12);
        wr(OFS_CTRL, c);
        repeat (3) @(negedge clk);
        mon_nb = 0; mon_word = '0;
        mon_on = 1;
    endtask

    task automatic clr_edges();
        edge_cnt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: rebuild frames from the wire and compare with the scoreboard
    always @(sclk) begin
        if (!rst) begin
            edge_cnt++;
            if (edge_cnt == 1) first_edge = cyc;
            if (edge_cnt == 2) second_edge = cyc;
            last_edge = cyc;
            if (mon_on) begin
                bit lead;
                lead = (sclk != tb_cpol);
                if (tb_cpha ? !lead : lead) begin
                    int slot;
                    slot = tb_msb ? (tb_wm1 - mon_nb) : mon_nb;
                    mon_word[slot] = mosi;
                    mon_nb++;
                    if (mon_nb == tb_wm1 + 1) begin
                        if (exp_q.size() == 0) begin
                            chk("R8 unexpected frame on wire", mon_word, 16'hDEAD);
                        end else begin
                            logic [15:0] e;
                            e = exp_q.pop_front();
                            chk("R5/R6 frame on mosi", mon_word, e);
                        end
                        mon_nb = 0; mon_word = '0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        longint c0, t7, t0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sclk idle", sclk, 0);
        chk("R1 mosi idle", mosi, 0);
        chk("R1 irq low", irq, 0);
        rd_chk(OFS_CTRL, 0, "R1 ctrl reset");
        rd_chk(OFS_DIV, 0, "R1 divisor reset");
        rd_chk(OFS_RX, 0, "R1 empty receive");

        // R2 register map
        wr(OFS_DIV, 7);
        rd_chk(OFS_DIV, 7, "R2 divisor readback");
        wr(OFS_IEN, 4);
        rd_chk(OFS_IEN, 4, "R2 irq enable readback");
        wr(OFS_IEN, 0);

        // R11/R4/R7: two 8-bit MSB-first frames in loopback, mode 0
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        rd_chk(OFS_CTRL, 32'h1F17, "R2 ctrl readback");
        clr_edges();
        send(32'hA5, 1);
        send(32'h3C, 1);
        idle(2 * 16 * 7 + 20);
        chk("R11 edge count for two frames", edge_cnt, 32);
        chk("R11 gapless span", last_edge - first_edge, 31 * 7);
        rd_chk(OFS_RX, 32'hA5, "R7 loopback word 0");
        rd_chk(OFS_RX, 32'h3C, "R7 loopback word 1");

        // R3 half period follows divisor
        wr(OFS_DIV, 9);
        clr_edges();
        send(32'h81, 1);
        idle(16 * 9 + 20);
        chk("R3 half period 9", second_edge - first_edge, 9);
        rd_chk(OFS_RX, 32'h81, "R3 word after divisor change");
        wr(OFS_DIV, 7);

        // R4/R5/R6: 12-bit LSB-first, cpol 1, cpha 1
        cfg(11, 0, 1, 1, 1, 1, 1, 1, 0);
        chk("R6 idle high", sclk, 1);
        send(32'hF0ABC, 1);
        send(32'h123, 1);
        idle(2 * 24 * 7 + 20);
        rd_chk(OFS_RX, 32'hABC, "R4 right-justified 12-bit");
        rd_chk(OFS_RX, 32'h123, "R5 lsb-first word");
        chk("R6 back at idle high", sclk, 1);

        // R6: 16-bit, cpol 0, cpha 1
        cfg(15, 1, 1, 0, 1, 1, 1, 1, 0);
        send(32'hBEEF, 1);
        idle(32 * 7 + 20);
        rd_chk(OFS_RX, 32'hBEEF, "R6 cpha1 16-bit");

        // R7: external input when loopback is off
        cfg(15, 1, 0, 0, 1, 1, 0, 1, 0);
        miso = 1'b1;
        send(32'h1234, 1);
        idle(32 * 7 + 20);
        rd_chk(OFS_RX, 32'hFFFF, "R7 miso high");
        miso = 1'b0;
        send(32'h00FF, 1);
        idle(32 * 7 + 20);
        rd_chk(OFS_RX, 32'h0000, "R7 miso low");

        // R8: master bit clear holds the frame
        cfg(7, 1, 0, 0, 0, 1, 1, 1, 0);
        clr_edges();
        send(32'h5A, 1);
        idle(200);
        chk("R8 no clock without master", edge_cnt, 0);
        rd_chk(OFS_RX, 0, "R8 nothing received");
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        idle(16 * 7 + 20);
        rd_chk(OFS_RX, 32'h5A, "R8 sent once master set");

        // R9: transmit overfill while stopped, then drain
        cfg(7, 1, 0, 0, 1, 0, 1, 1, 0);
        for (int i = 0; i < 10; i++) send(32'h10 + i, i < 8);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        idle(8 * 16 * 7 + 20);
        for (int i = 0; i < 8; i++) rd_chk(OFS_RX, 32'h10 + i, "R9 eight-deep queues");
        rd_chk(OFS_RX, 0, "R10 empty read returns 0");

        // R10: receive overflow keeps the oldest
        for (int i = 0; i < 8; i++) send(32'h40 + i, 1);
        idle(8 * 16 * 7 + 20);
        send(32'h50, 1);
        send(32'h51, 1);
        idle(2 * 16 * 7 + 20);
        for (int i = 0; i < 8; i++) rd_chk(OFS_RX, 32'h40 + i, "R10 oldest kept");
        rd_chk(OFS_RX, 0, "R10 overflow discarded");

        // R9: single-entry queues when queue enables are clear
        cfg(7, 1, 0, 0, 1, 0, 1, 0, 0);
        send(32'h61, 1);
        send(32'h62, 0);
        send(32'h63, 0);
        cfg(7, 1, 0, 0, 1, 1, 1, 0, 0);
        idle(3 * 16 * 7 + 20);
        rd_chk(OFS_RX, 32'h61, "R9 single entry word");
        rd_chk(OFS_RX, 0, "R9 extra writes dropped");

        // R12 interrupt
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        wr(OFS_IEN, 4);
        idle(3);
        chk("R12 irq when drained", irq, 1);
        send(32'h77, 1);
        idle(3);
        chk("R12 irq low while busy", irq, 0);
        idle(16 * 7 + 20);
        chk("R12 irq after last frame", irq, 1);
        rd_chk(OFS_RX, 32'h77, "R12 word");
        wr(OFS_IEN, 0);
        idle(2);
        chk("R12 irq removed", irq, 0);

        // R13 soft reset flushes queued words
        cfg(7, 1, 0, 0, 1, 0, 1, 1, 0);
        send(32'h01, 0);
        send(32'h02, 0);
        cfg(7, 1, 0, 0, 1, 0, 1, 1, 1);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        clr_edges();
        idle(300);
        chk("R13 flushed, no clock", edge_cnt, 0);
        rd_chk(OFS_RX, 0, "R13 receive flushed");
        // R13 abort mid-frame
        mon_on = 0;
        send(32'h99, 0);
        idle(40);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 1);
        mon_on = 0;
        chk("R13 sclk idle during reset", sclk, 0);
        clr_edges();
        idle(60);
        chk("R13 no clock during reset", edge_cnt, 0);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);
        mon_on = 0;
        idle(200);
        rd_chk(OFS_RX, 0, "R13 aborted frame not stored");

        // R3 zero divisor means 65536
        clr_edges();
        send(32'hC3, 0);
        c0 = cyc;
        wait (edge_cnt > 0);
        t7 = first_edge - c0;
        idle(16 * 7 + 20);
        rd_chk(OFS_RX, 32'hC3, "R3 reference frame");
        wr(OFS_DIV, 0);
        clr_edges();
        send(32'hC3, 0);
        c0 = cyc;
        wait (edge_cnt > 0);
        t0 = first_edge - c0;
        chk("R3 zero divisor half period", t0 - t7, 65536 - 7);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 1);
        cfg(7, 1, 0, 0, 1, 1, 1, 1, 0);

        chk("R5 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule